// File: doc/BRIEF.md
# Host Interrupt Status and Mask Controller

The block gathers up to sixteen single-cycle event pulses from the device side into a sticky status register and raises one host interrupt line whenever an unmasked status bit is set. The host reaches it over a small single-port register bus. One request (`req_i`) carries a write enable, a word address and write data. Read data is registered and appears in the cycle after the request.

Six word addresses are decoded. Address 0 is the mask, which reads and writes directly. Address 1 sets mask bits and address 2 clears them; both are write-only and change only the bits written as 1. Address 3 returns the status without changing it. Address 4 returns the status and clears every bit. Address 5 takes a write-one acknowledge that clears the selected status bits. A source pulse always wins over a clear in the same cycle, so no event is lost.

Source positions are fixed by the device: 0 and 3 are the two receive buffers, 1 is transmit data, 2 is transmit transfer, 4 is receive transfer, 5 and 6 are the event mailbox, 7 is wake, 8 and 9 are trace, 10 is command complete and 14 is init complete. The controller treats all sources alike.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset the mask is 0x0001 (only source 0 masked), the status is zero, `irq_o` is 0 and `rdata_o` is 0.
- R2: A write to address 0 loads the mask from `wdata_i[NUM_SRC-1:0]`, and the upper write bits are ignored. A read of address 0 returns the mask, zero-extended.
- R3: A write to address 1 sets each mask bit whose write bit is 1 and leaves the other mask bits unchanged.
- R4: A write to address 2 clears each mask bit whose write bit is 1 and leaves the other mask bits unchanged.
- R5: A 1 on `src_i[i]` for one cycle sets status bit i, and the bit stays set after the pulse ends.
- R6: A read of address 3 returns the status and leaves it unchanged.
- R7: A read of address 4 returns the status as it was before the read, then clears all status bits.
- R8: A write to address 5 clears each status bit whose write bit is 1 and leaves the other status bits unchanged.
- R9: A source pulse in the same cycle as an acknowledge or a clear-on-read of its bit leaves that bit set.
- R10: `irq_o` is 1 exactly when some status bit is set whose mask bit is 0. It follows the registered status and mask with no further delay.
- R11: Read data is registered and appears the cycle after the request. Reads of the write-only addresses 1, 2 and 5 and of unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Single-cycle event pulses, one per source |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after a read request |
| irq_o | output | 1 | Host interrupt, active high |

## Verification
The bench builds the block with its defaults: sixteen sources on a 32-bit data bus, and a reset mask of 0x0001. With these values it can write ones into the upper half of the data word and show that they are dropped, and it can reach the top source bit 15. Because source 0 starts masked, the bench can show that an interrupt stays silent straight after reset. Source pulses are driven in the same cycle as an acknowledge and as a clear-on-read, so both collision cases are covered.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_MASK      = 3'd0,
    RA_MASK_SET  = 3'd1,
    RA_MASK_CLR  = 3'd2,
    RA_STAT_KEEP = 3'd3,
    RA_STAT_POP  = 3'd4,
    RA_ACK       = 3'd5
  } reg_addr_e;

  // device source positions
  localparam int unsigned SRC_RX_BUF_A  = 0;
  localparam int unsigned SRC_TX_DATA   = 1;
  localparam int unsigned SRC_TX_XFER   = 2;
  localparam int unsigned SRC_RX_BUF_B  = 3;
  localparam int unsigned SRC_RX_XFER   = 4;
  localparam int unsigned SRC_MBOX_0    = 5;
  localparam int unsigned SRC_MBOX_1    = 6;
  localparam int unsigned SRC_WAKE      = 7;
  localparam int unsigned SRC_TRACE_0   = 8;
  localparam int unsigned SRC_TRACE_1   = 9;
  localparam int unsigned SRC_CMD_DONE  = 10;
  localparam int unsigned SRC_INIT_DONE = 14;
endpackage

// File: rtl/host_irq_decode.sv
module host_irq_decode
  import host_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM_SRC-1:0]    mask_i,
  input  logic [NUM_SRC-1:0]    status_i,
  output logic                  mask_wr_o,
  output logic [NUM_SRC-1:0]    mask_wdata_o,
  output logic [NUM_SRC-1:0]    mask_set_o,
  output logic [NUM_SRC-1:0]    mask_clr_o,
  output logic [NUM_SRC-1:0]    ack_o,
  output logic                  pop_o,
  output logic [DATA_W-1:0]     rdata_o
);
  logic                  wr, rd;
  logic [NUM_SRC-1:0]    wbits;
  logic [DATA_W-1:0]     rdata_d;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign wbits = wdata_i[NUM_SRC-1:0];

  generate
    if (DATA_W > NUM_SRC) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^wdata_i[DATA_W-1:NUM_SRC];
    end
  endgenerate

  assign mask_wr_o    = wr && (addr_i == RA_MASK);
  assign mask_wdata_o = wbits;
  assign mask_set_o   = (wr && (addr_i == RA_MASK_SET)) ? wbits : '0;
  assign mask_clr_o   = (wr && (addr_i == RA_MASK_CLR)) ? wbits : '0;
  assign ack_o        = (wr && (addr_i == RA_ACK)) ? wbits : '0;
  assign pop_o        = rd && (addr_i == RA_STAT_POP);

  always_comb begin
    rdata_d = '0;
    if (rd) begin
      case (addr_i)
        RA_MASK:                  rdata_d[NUM_SRC-1:0] = mask_i;
        RA_STAT_KEEP, RA_STAT_POP: rdata_d[NUM_SRC-1:0] = status_i;
        default:                  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rdata_d;
  end
endmodule

// File: rtl/host_irq_mask.sv
module host_irq_mask #(
  parameter int unsigned       NUM_SRC = 16,
  parameter logic [NUM_SRC-1:0] RST_VAL = NUM_SRC'(1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_d;

  // set wins over clear if both ever arrive together
  always_comb begin
    if (wr_i) mask_d = wdata_i;
    else      mask_d = (mask_o | set_i) & ~(clr_i & ~set_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_o <= RST_VAL;
    else         mask_o <= mask_d;
  end
endmodule

// File: rtl/host_irq_status.sv
module host_irq_status #(
  parameter int unsigned NUM_SRC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] ack_i,
  input  logic               pop_i,
  output logic [NUM_SRC-1:0] status_o
);
  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      // new event beats any clear in the same cycle
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) status_o[i] <= 1'b0;
        else         status_o[i] <= src_i[i] | (status_o[i] & ~ack_i[i] & ~pop_i);
      end
    end
  endgenerate
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import host_irq_pkg::*;
#(
  parameter int unsigned        NUM_SRC  = 16,
  parameter int unsigned        DATA_W   = 32,
  parameter logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  irq_o
);
  logic [NUM_SRC-1:0] mask_q, status_q;
  logic [NUM_SRC-1:0] mask_wdata, mask_set, mask_clr, ack;
  logic               mask_wr, pop;

  host_irq_decode #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_decode (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .mask_i(mask_q), .status_i(status_q),
    .mask_wr_o(mask_wr), .mask_wdata_o(mask_wdata),
    .mask_set_o(mask_set), .mask_clr_o(mask_clr),
    .ack_o(ack), .pop_o(pop), .rdata_o
  );

  host_irq_mask #(.NUM_SRC(NUM_SRC), .RST_VAL(MASK_RST)) u_mask (
    .clk_i, .rst_ni, .wr_i(mask_wr), .wdata_i(mask_wdata),
    .set_i(mask_set), .clr_i(mask_clr), .mask_o(mask_q)
  );

  host_irq_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk_i, .rst_ni, .src_i, .ack_i(ack), .pop_i(pop), .status_o(status_q)
  );

  assign irq_o = |(status_q & ~mask_q);
endmodule

// File: rtl/host_irq_ctrl_chk.sv
module host_irq_ctrl_chk
  import host_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned DATA_W  = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_SRC-1:0]    src_i,
  input logic                  req_i,
  input logic                  we_i,
  input logic [REG_ADDR_W-1:0] addr_i,
  input logic [NUM_SRC-1:0]    wbits_i,
  input logic [DATA_W-1:0]     rdata_i,
  input logic                  irq_i,
  input logic [NUM_SRC-1:0]    mask_i,
  input logic [NUM_SRC-1:0]    status_i
);
  assert_irq_needs_status_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (status_i != '0));

  assert_src_sticks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((status_i & $past(src_i)) == $past(src_i)));

  assert_mask_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == RA_MASK_SET) |=> ((mask_i & $past(wbits_i)) == $past(wbits_i)));

  assert_mask_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == RA_MASK_CLR) |=> ((mask_i & $past(wbits_i)) == '0));

  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == RA_ACK) |=> ((status_i & $past(wbits_i) & ~$past(src_i)) == '0));

  assert_pop_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == RA_STAT_POP) |=> (status_i == $past(src_i)));

  assert_keep_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == RA_STAT_KEEP) |=> (status_i == ($past(status_i) | $past(src_i))));

  assert_mask_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == RA_MASK) |=> (rdata_i == DATA_W'($past(mask_i))));
endmodule

bind host_irq_ctrl host_irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
  .addr_i(addr_i), .wbits_i(wdata_i[NUM_SRC-1:0]), .rdata_i(rdata_o),
  .irq_i(irq_o), .mask_i(mask_q), .status_i(status_q)
);

// File: tb/host_irq_ctrl_test.sv
module host_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          req = 1'b0, we = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all drives at negedge; outputs sampled at the following negedge
  task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d, input logic [NS-1:0] s);
    req = 1; we = 1; addr = a; wdata = d; src = s;
    @(negedge clk);
    req = 0; we = 0; wdata = '0; src = '0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [NS-1:0] s, output logic [DW-1:0] d);
    req = 1; we = 0; addr = a; src = s;
    @(negedge clk);
    req = 0; src = '0;
    d = rdata;
  endtask

  task automatic pulse(input logic [NS-1:0] s);
    src = s;
    @(negedge clk);
    src = '0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    chk("R1 rdata", rdata, '0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    bus_read(3'd0, '0, d); chk("R1 mask", d, 32'h1);
    bus_read(3'd3, '0, d); chk("R1 status", d, 32'h0);
    pulse(16'h0001);
    chk("R10 src0 masked after reset", {31'd0, irq}, 32'd0);
    bus_read(3'd4, '0, d); chk("R7 pop returns src0", d, 32'h1);
  endtask

  task automatic t_mask;
    logic [DW-1:0] d;
    bus_write(3'd0, 32'hFFFF_1234, '0);
    bus_read(3'd0, '0, d); chk("R2 mask write drops upper", d, 32'h1234);
    bus_write(3'd1, 32'h0101, '0);
    bus_read(3'd0, '0, d); chk("R3 mask set", d, 32'h1335);
    bus_write(3'd2, 32'h0030, '0);
    bus_read(3'd0, '0, d); chk("R4 mask clear", d, 32'h1305);
    bus_write(3'd2, 32'hFFFF, '0);
    bus_read(3'd0, '0, d); chk("R4 mask clear all", d, 32'h0);
  endtask

  task automatic t_sticky;
    logic [DW-1:0] d;
    pulse(16'h8004);
    @(negedge clk);
    chk("R10 irq unmasked", {31'd0, irq}, 32'd1);
    bus_read(3'd3, '0, d); chk("R5 sticky status", d, 32'h8004);
    bus_read(3'd3, '0, d); chk("R6 second keep read", d, 32'h8004);
    bus_write(3'd1, 32'h8004, '0);
    chk("R10 irq masked", {31'd0, irq}, 32'd0);
    bus_read(3'd3, '0, d); chk("R10 status kept while masked", d, 32'h8004);
    bus_write(3'd2, 32'h0004, '0);
    chk("R10 irq after unmask", {31'd0, irq}, 32'd1);
    bus_write(3'd0, 32'h0, '0);
  endtask

  task automatic t_ack;
    logic [DW-1:0] d;
    pulse(16'h0022);
    bus_read(3'd3, '0, d); chk("R5 status accumulates", d, 32'h8026);
    bus_write(3'd5, 32'h8024, '0);
    bus_read(3'd3, '0, d); chk("R8 ack selected bits", d, 32'h0002);
    bus_read(3'd1, '0, d); chk("R11 write-only reads 0", d, 32'h0);
    bus_read(3'd5, '0, d); chk("R11 ack reg reads 0", d, 32'h0);
    bus_read(3'd4, '0, d); chk("R7 pop returns old", d, 32'h0002);
    chk("R7 irq after pop", {31'd0, irq}, 32'd0);
    bus_read(3'd3, '0, d); chk("R7 status cleared", d, 32'h0);
  endtask

  task automatic t_collide;
    logic [DW-1:0] d;
    pulse(16'h0408);
    bus_write(3'd5, 32'h0408, 16'h0008);
    bus_read(3'd3, '0, d); chk("R9 src beats ack", d, 32'h0008);
    bus_read(3'd4, 16'h4080, d); chk("R9 pop returns pre-state", d, 32'h0008);
    bus_read(3'd3, '0, d); chk("R9 src beats pop", d, 32'h4080);
    req = 1; we = 0; addr = 3'd3;
    @(negedge clk);
    req = 0;
    @(negedge clk);
    chk("R11 rdata one cycle only", rdata, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_sticky();
    t_ack();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule